// File: doc/BRIEF.md
# Dual-Mode PFC Voltage-Loop Compensator

This block produces the outer voltage-loop command of a power-factor-correction stage. It receives a stream of output-voltage samples, each marked by a valid strobe, and a separate strobe that fires at every AC zero crossing. At each zero crossing it keeps the sample present on the bus. The output voltage at that instant equals its average, so in steady state the loop regulates on this held value and never sees the ripple at twice the line frequency.

On every valid sample the block first forms the instantaneous error, reference minus the live sample. If that error is below a programmable threshold, the loop uses the held zero-crossing value and a slow pair of proportional and integral gains. If the error is at or above the threshold, as happens during a load step, the loop uses the live sample and a separate fast gain pair so that the output voltage recovers quickly. A proportional-integral stage with clamped integrator and clamped output produces a signed fixed-point command for the current loop that follows it.

Top module: `pfc_vloop_comp`

## Requirements
- R1: The held value is loaded from `vout_smp` only in a cycle with `zc_stb` high. Until the first such load after reset, the held value follows `vref`, so the averaged-mode error is zero.
- R2: When the instantaneous error `vref - vout_smp` (signed) is below `err_thresh`, the error used is `vref - held` and the gains are `kp_avg`, `ki_avg`.
- R3: When the instantaneous error is greater than or equal to `err_thresh`, including the equal case, the error used is `vref - vout_smp` and the gains are `kp_fast`, `ki_fast`.
- R4: A negative instantaneous error (sample above the reference) always selects the averaged mode of R2.
- R5: Gains are signed fixed-point with GF fraction bits (GF=8 by default). On each update the integrator adds Ki·error, and the output is floor((Kp·error + new integrator) / 2^GF). The default variant truncates toward minus infinity.
- R6: The integrator saturates at `out_min`·2^GF and `out_max`·2^GF, so an integrator driven into a limit recovers without windup.
- R7: `loop_out` is clamped to the range [`out_min`, `out_max`].
- R8: The loop updates only at a clock edge with `smp_valid` high. Otherwise `loop_out` and the integrator hold, whatever the other inputs do.
- R9: When `zc_stb` and `smp_valid` are high in the same cycle, that update uses the previously held value, and the new held value applies from the next update on.
- R10: Reset (`rst_n` low) clears `loop_out` and the integrator to zero and discards the held value. The result appears one clock after the update edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vref | input | DW | Output-voltage reference, unsigned |
| err_thresh | input | DW | Error level that selects the fast mode, unsigned |
| kp_avg | input | GW | Proportional gain, averaged mode, signed Q.GF |
| ki_avg | input | GW | Integral gain, averaged mode, signed Q.GF |
| kp_fast | input | GW | Proportional gain, fast mode, signed Q.GF |
| ki_fast | input | GW | Integral gain, fast mode, signed Q.GF |
| out_min | input | OW | Lower limit of output and integrator, signed |
| out_max | input | OW | Upper limit of output and integrator, signed |
| vout_smp | input | DW | Output-voltage sample, unsigned |
| smp_valid | input | 1 | Sample strobe that triggers a loop update |
| zc_stb | input | 1 | AC zero-crossing strobe that captures vout_smp |
| loop_out | output | OW | Clamped loop command, signed |

## Verification
The loop is driven with live samples slightly below the reference, which must regulate on the held value, and with deep sags, which must switch to the live sample and the fast gains. An error exactly equal to the threshold separates a `>=` decision from a `>`, and a sample above the reference checks that negative errors never select the fast mode. A zero-crossing strobe in the same cycle as a sample separates old-held from new-held behaviour. Long runs into both output limits, followed by a reversal of the error, separate a clamped integrator from one that has wound up, because the recovery values differ. A half-step negative result checks that truncation goes toward minus infinity.

// File: rtl/pfc_vloop_pkg.sv
package pfc_vloop_pkg;

   typedef enum logic {
      LOOP_AVG  = 1'b0,
      LOOP_FAST = 1'b1
   } loop_mode_e;

   typedef enum int {
      SCALE_FLOOR   = 0,
      SCALE_NEAREST = 1
   } scale_mode_e;

endpackage

// File: rtl/vloop_zc_hold.sv
module vloop_zc_hold #(
   parameter int DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          zc_stb,
   input  logic [DW-1:0] vout_smp,
   input  logic [DW-1:0] vref,
   output logic [DW-1:0] held_val
);

   logic [DW-1:0] cap_q;
   logic          cap_ok_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_q    <= '0;
         cap_ok_q <= 1'b0;
      end else if (zc_stb) begin
         cap_q    <= vout_smp;
         cap_ok_q <= 1'b1;
      end
   end

   // before any crossing has been seen, track the reference (zero error)
   assign held_val = cap_ok_q ? cap_q : vref;

   // R1: capture only on a crossing strobe
   p_held_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      zc_stb |=> (cap_ok_q && cap_q == $past(vout_smp)));

   p_held_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !zc_stb |=> ($stable(cap_q) && $stable(cap_ok_q)));

endmodule

// File: rtl/vloop_err_sel.sv
module vloop_err_sel
   import pfc_vloop_pkg::*;
#(
   parameter int DW = 12,
   parameter int GW = 16,
   localparam int EW = DW + 1
) (
   input  logic [DW-1:0]        vref,
   input  logic [DW-1:0]        vout_smp,
   input  logic [DW-1:0]        held_val,
   input  logic [DW-1:0]        err_thresh,
   input  logic signed [GW-1:0] kp_avg,
   input  logic signed [GW-1:0] ki_avg,
   input  logic signed [GW-1:0] kp_fast,
   input  logic signed [GW-1:0] ki_fast,
   output logic signed [EW-1:0] err_sel,
   output logic signed [GW-1:0] kp_sel,
   output logic signed [GW-1:0] ki_sel
);

   logic signed [EW-1:0] live_err;
   logic signed [EW-1:0] avg_err;
   logic signed [EW-1:0] thr_s;
   loop_mode_e           mode;

   assign live_err = $signed({1'b0, vref}) - $signed({1'b0, vout_smp});
   assign avg_err  = $signed({1'b0, vref}) - $signed({1'b0, held_val});
   assign thr_s    = $signed({1'b0, err_thresh});

   // at or above the threshold: fast path (R3); below, including negative: averaged (R2, R4)
   assign mode = (live_err >= thr_s) ? LOOP_FAST : LOOP_AVG;

   always_comb begin
      unique case (mode)
         LOOP_FAST: begin
            err_sel = live_err;
            kp_sel  = kp_fast;
            ki_sel  = ki_fast;
         end
         default: begin
            err_sel = avg_err;
            kp_sel  = kp_avg;
            ki_sel  = ki_avg;
         end
      endcase
   end

endmodule

// File: rtl/vloop_pi.sv
module vloop_pi
   import pfc_vloop_pkg::*;
#(
   parameter int EW         = 13,
   parameter int GW         = 16,
   parameter int GF         = 8,
   parameter int OW         = 16,
   parameter int SCALE_MODE = SCALE_FLOOR
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 upd,
   input  logic signed [EW-1:0] err,
   input  logic signed [GW-1:0] kp,
   input  logic signed [GW-1:0] ki,
   input  logic signed [OW-1:0] lim_lo,
   input  logic signed [OW-1:0] lim_hi,
   output logic signed [OW-1:0] out
);

   localparam int PW = EW + GW;
   localparam int IW = PW + 1;
   localparam int SW = IW + 1;

   initial begin
      assert (OW + GF < IW) else $error("vloop_pi: OW+GF must be below integrator width");
      assert (GF < GW) else $error("vloop_pi: GF must leave integer gain bits");
      assert (SCALE_MODE == SCALE_FLOOR || GF >= 1)
         else $error("vloop_pi: rounding needs at least one fraction bit");
   end

   logic signed [PW-1:0] prod_p, prod_i;
   logic signed [IW-1:0] integ_q, integ_nx, ilo, ihi;
   logic signed [SW-1:0] isum, total, scaled, olo, ohi;
   logic signed [OW-1:0] out_q, out_nx;

   assign prod_p = $signed({{GW{err[EW-1]}}, err}) * $signed({{EW{kp[GW-1]}}, kp});
   assign prod_i = $signed({{GW{err[EW-1]}}, err}) * $signed({{EW{ki[GW-1]}}, ki});

   // integrator limits: output limits carried to the product scale
   assign ilo = $signed({{(IW-OW){lim_lo[OW-1]}}, lim_lo}) <<< GF;
   assign ihi = $signed({{(IW-OW){lim_hi[OW-1]}}, lim_hi}) <<< GF;

   assign isum = $signed({integ_q[IW-1], integ_q})
               + $signed({{(SW-PW){prod_i[PW-1]}}, prod_i});

   always_comb begin
      if (isum < $signed({ilo[IW-1], ilo}))
         integ_nx = ilo;
      else if (isum > $signed({ihi[IW-1], ihi}))
         integ_nx = ihi;
      else
         integ_nx = isum[IW-1:0];
   end

   assign total = $signed({{(SW-PW){prod_p[PW-1]}}, prod_p})
                + $signed({integ_nx[IW-1], integ_nx});

   generate
      if (SCALE_MODE == SCALE_NEAREST) begin : g_round
         localparam logic signed [SW-1:0] HALF = SW'(1) <<< (GF - 1);
         assign scaled = (total + HALF) >>> GF;
      end else begin : g_floor
         assign scaled = total >>> GF;
      end
   endgenerate

   assign olo = $signed({{(SW-OW){lim_lo[OW-1]}}, lim_lo});
   assign ohi = $signed({{(SW-OW){lim_hi[OW-1]}}, lim_hi});

   always_comb begin
      if (scaled < olo)
         out_nx = lim_lo;
      else if (scaled > ohi)
         out_nx = lim_hi;
      else
         out_nx = scaled[OW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         integ_q <= '0;
         out_q   <= '0;
      end else if (upd) begin
         integ_q <= integ_nx;
         out_q   <= out_nx;
      end
   end

   assign out = out_q;

   // R8: no update without a sample strobe
   p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(out_q));

   p_integ_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(integ_q));

   // R7: output inside the limits that were present at the update
   p_out_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (out_q >= $past(lim_lo) && out_q <= $past(lim_hi)));

   // R6: integrator inside the scaled limits
   p_integ_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (integ_q >= $past(ilo) && integ_q <= $past(ihi)));

endmodule

// File: rtl/pfc_vloop_comp.sv
module pfc_vloop_comp
   import pfc_vloop_pkg::*;
#(
   parameter int DW         = 12,
   parameter int GW         = 16,
   parameter int GF         = 8,
   parameter int OW         = 16,
   parameter int SCALE_MODE = SCALE_FLOOR
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DW-1:0]        vref,
   input  logic [DW-1:0]        err_thresh,
   input  logic signed [GW-1:0] kp_avg,
   input  logic signed [GW-1:0] ki_avg,
   input  logic signed [GW-1:0] kp_fast,
   input  logic signed [GW-1:0] ki_fast,
   input  logic signed [OW-1:0] out_min,
   input  logic signed [OW-1:0] out_max,
   input  logic [DW-1:0]        vout_smp,
   input  logic                 smp_valid,
   input  logic                 zc_stb,
   output logic signed [OW-1:0] loop_out
);

   localparam int EW = DW + 1;

   initial begin
      assert (DW >= 2) else $error("pfc_vloop_comp: DW too small");
      assert (OW >= 2) else $error("pfc_vloop_comp: OW too small");
   end

   logic [DW-1:0]        held_val;
   logic signed [EW-1:0] err_sel;
   logic signed [GW-1:0] kp_sel, ki_sel;

   vloop_zc_hold #(.DW(DW)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .zc_stb   (zc_stb),
      .vout_smp (vout_smp),
      .vref     (vref),
      .held_val (held_val)
   );

   vloop_err_sel #(.DW(DW), .GW(GW)) u_sel (
      .vref       (vref),
      .vout_smp   (vout_smp),
      .held_val   (held_val),
      .err_thresh (err_thresh),
      .kp_avg     (kp_avg),
      .ki_avg     (ki_avg),
      .kp_fast    (kp_fast),
      .ki_fast    (ki_fast),
      .err_sel    (err_sel),
      .kp_sel     (kp_sel),
      .ki_sel     (ki_sel)
   );

   vloop_pi #(
      .EW(EW), .GW(GW), .GF(GF), .OW(OW), .SCALE_MODE(SCALE_MODE)
   ) u_pi (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd    (smp_valid),
      .err    (err_sel),
      .kp     (kp_sel),
      .ki     (ki_sel),
      .lim_lo (out_min),
      .lim_hi (out_max),
      .out    (loop_out)
   );

endmodule

// File: tb/pfc_vloop_comp_bench.sv
module pfc_vloop_comp_bench;

   localparam int DW = 12;
   localparam int GW = 16;
   localparam int OW = 16;
   localparam int NV = 20;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [DW-1:0]        vref = 12'd2000;
   logic [DW-1:0]        err_thresh = 12'd50;
   logic signed [GW-1:0] kp_avg = 16'sd256;   // 1.0
   logic signed [GW-1:0] ki_avg = 16'sd128;   // 0.5
   logic signed [GW-1:0] kp_fast = 16'sd1024; // 4.0
   logic signed [GW-1:0] ki_fast = 16'sd512;  // 2.0
   logic signed [OW-1:0] out_min = -16'sd1000;
   logic signed [OW-1:0] out_max = 16'sd3000;
   logic [DW-1:0]        vout_smp = '0;
   logic                 smp_valid = 1'b0;
   logic                 zc_stb = 1'b0;
   logic signed [OW-1:0] loop_out;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   pfc_vloop_comp u_pfc_vloop_comp (
      .clk(clk), .rst_n(rst_n), .vref(vref), .err_thresh(err_thresh),
      .kp_avg(kp_avg), .ki_avg(ki_avg), .kp_fast(kp_fast), .ki_fast(ki_fast),
      .out_min(out_min), .out_max(out_max), .vout_smp(vout_smp),
      .smp_valid(smp_valid), .zc_stb(zc_stb), .loop_out(loop_out)
   );

   // vectors: sample, valid, crossing strobe, expected output after the edge
   localparam int V_SMP [NV] = '{1990, 1980, 1995, 1900, 1950, 1951, 2100, 2000, 1000, 1000,
                                 1000, 1999, 4095, 2000, 2000, 2000, 2000, 2000, 2000, 1940};
   localparam bit V_VAL [NV] = '{1, 0, 1, 1, 1, 1, 1, 1, 0, 1,
                                 1, 1, 0, 1, 1, 1, 1, 0, 1, 1};
   localparam bit V_ZC  [NV] = '{0, 1, 0, 0, 0, 0, 1, 0, 0, 0,
                                 0, 0, 1, 0, 0, 0, 0, 1, 0, 0};
   localparam int V_EXP [NV] = '{0, 0, 30, 610, 510, 340, 350, 180, 180, 3000,
                                 3000, 2850, 2850, -193, -1000, -1000, -1000, -1000, -1000, -640};
   // 0:R1 R10 held follows vref  1:R1 R8 capture without update  2:R2 R5
   // 3:R3 deep sag  4:R3 error equal to threshold  5:R2 just below threshold
   // 6:R9 R4 strobe with sample, negative error  7:R9 new held used  8:R8 ignored sample
   // 9:R7 upper clamp  10:R6 integrator at top  11:R6 recovery without windup
   // 12:R1 capture 4095  13:R5 floor of -192.5  14-16:R7 R6 lower limits
   // 17:R1 recapture  18:R2 zero error  19:R6 R3 recovery from lower limit

   task automatic check(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s: loop_out=%0d expected=%0d", tag, got, exp);
      end
   endtask

   task automatic step(input int smp, input bit val, input bit zc);
      @(negedge clk);
      vout_smp  = DW'(smp);
      smp_valid = val;
      zc_stb    = zc;
      @(negedge clk);
      smp_valid = 1'b0;
      zc_stb    = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 reset output", int'(loop_out), 0);

      for (int i = 0; i < NV; i++) begin
         step(V_SMP[i], V_VAL[i], V_ZC[i]);
         check($sformatf("vector %0d", i), int'(loop_out), V_EXP[i]);
      end

      // R10: reset mid-run clears output, integrator and held value
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R10 output after reset", int'(loop_out), 0);

      // R1: held follows a changed reference after reset, error zero
      vref = 12'd2010;
      step(2005, 1'b1, 1'b0);
      check("R1 held tracks vref", int'(loop_out), 0);

      // R3 R10: integrator restarted from zero; err 60 fast gains -> (61440+30720)/256
      step(1950, 1'b1, 1'b0);
      check("R3 fast after reset", int'(loop_out), 360);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule